// File: doc/BRIEF.md
# Posted Write Target Acceptor

This block is the target half of a bus bridge for PCI memory writes. It watches the shared bus and claims memory write and memory-write-and-invalidate bursts whose address falls inside a base/limit window. It takes the burst into a posted write queue, so the initiator does not have to wait for the far bus. Each claimed transaction leaves one address entry in the queue, followed by data entries. The final data entry is marked, so the delivery side can find where a transaction ends.

A write is claimed only when the queue reports room for the address plus a minimum of eight data Dwords. DEVSEL# asserts with medium timing. TRDY# follows one clock later and then stays asserted, so a Dword is taken on every clock in which IRDY# is asserted. The block disconnects on its own, by asserting STOP# together with TRDY#, when the next Dword would cross an internal boundary or when the current Dword takes the last free queue slot. The boundary is a cache line for memory-write-and-invalidate and an aligned 4 KB page for plain memory write.

Top module: `pwt_acceptor`

## Requirements
- R1: A transaction is claimed only if its command is memory write (C/BE# = 4'b0111) or memory-write-and-invalidate (C/BE# = 4'b1111), and its address lies within [WIN_BASE, WIN_LIMIT]. Any other command or address leaves DEVSEL#, TRDY# and STOP# deasserted and pushes nothing.
- R2: A write that passes R1 is claimed only if `q_free` is at least 9 in the clock where FRAME# is first sampled asserted. Otherwise it is not claimed.
- R3: FRAME# is first sampled asserted at clock edge E0. After a claim, DEVSEL# is driven low after edge E1, so the bus first samples it at E2. TRDY# is driven low after edge E2.
- R4: Once TRDY# is low it stays low, with no wait states, through every data phase up to the final one. One Dword is taken at each clock edge where IRDY# and TRDY# are both low.
- R5: The first entry a claim pushes has tag 2'b01, `q_data` equal to the address phase AD and `q_be` equal to the raw command code. Each Dword taken is pushed with `q_data` = AD and `q_be` = ~C/BE#. Pushes appear one clock after the edge that caused them.
- R6: For memory-write-and-invalidate, STOP# is asserted together with TRDY# in the data phase of the last Dword of a cache line of CL_DW Dwords (8 by default).
- R7: For memory write, STOP# is asserted together with TRDY# in the data phase of the last Dword of an aligned 4 KB page.
- R8: STOP# is asserted in the data phase whose Dword takes the last of the `q_free` slots sampled at the claim. The total number of entries pushed for the transaction never exceeds that value.
- R9: After a Dword taken with STOP# asserted while FRAME# is still low, TRDY# goes high. DEVSEL# and STOP# stay low until FRAME# is sampled high, and are released one clock later. No entry is pushed in that interval.
- R10: A Dword taken while FRAME# is sampled high ends the transaction, and DEVSEL#, TRDY# and STOP# are all high one clock later.
- R11: Data entries carry tag 2'b10, except the final entry of the transaction. The final entry is the one taken with FRAME# high or STOP# low, and carries tag 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME#, sampled |
| irdy_n | input | 1 | IRDY#, sampled |
| ad | input | 32 | Address/data bus, sampled |
| cbe_n | input | 4 | Command / byte enables, sampled |
| q_free | input | FREE_W | Free entries in the posted write queue |
| devsel_n | output | 1 | DEVSEL# drive |
| trdy_n | output | 1 | TRDY# drive |
| stop_n | output | 1 | STOP# drive |
| q_push | output | 1 | Queue write strobe |
| q_tag | output | 2 | Entry tag: 01 address, 10 data, 11 last data |
| q_data | output | 32 | Entry address or data |
| q_be | output | 4 | Command code for address entries, active-high byte enables for data |

## Verification
The assertions rely on the initiator obeying the bus rules:
- FRAME# is deasserted only in a clock where IRDY# is asserted, and stays deasserted after that.
- IRDY# stays asserted once FRAME# is high.
- `q_free` never drops below the value sampled at the claim while a transaction is in progress, because only the delivery side frees entries.

The bench's initiator model keeps `q_free` constant across each burst. It drops FRAME# only together with a low IRDY#, and after a disconnect it ends the transaction within a clock. It draws random wait states, commands, window hits and misses, burst lengths and free counts, so every termination cause occurs.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,
    TAG_ADDR = 2'b01,
    TAG_DATA = 2'b10,
    TAG_LAST = 2'b11
  } qtag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DSEL,
    ST_XFER,
    ST_HOLD
  } st_e;

  localparam logic [3:0] CMD_MEMWR  = 4'b0111;
  localparam logic [3:0] CMD_MEMWRI = 4'b1111;
  localparam int unsigned PAGE_DW   = 1024;

  function automatic logic is_posted_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MEMWR) || (cmd == CMD_MEMWRI);
  endfunction

  // True when the Dword at address a is the final one of its block.
  function automatic logic at_block_end(input logic [31:0] a, input logic mwi,
                                        input int unsigned cl_dw);
    logic [31:0] mask;
    mask = mwi ? (32'(cl_dw) - 32'd1) : (32'(PAGE_DW) - 32'd1);
    return (({22'd0, a[11:2]} & mask) == mask);
  endfunction

endpackage

// File: rtl/pwt_claim.sv
module pwt_claim
  import pwt_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h1000_0000,
  parameter logic [31:0] WIN_LIMIT = 32'h1FFF_FFFF,
  parameter int unsigned FREE_W = 6,
  parameter int unsigned MIN_DATA = 8
) (
  input  logic [31:0]       addr,
  input  logic [3:0]        cmd,
  input  logic [FREE_W-1:0] q_free,
  output logic              hit,
  output logic              mwi
);
  localparam logic [FREE_W-1:0] NEED = FREE_W'(MIN_DATA + 1);

  logic in_win;
  logic room;

  assign in_win = (addr >= WIN_BASE) && (addr <= WIN_LIMIT);
  assign room   = (q_free >= NEED);
  assign hit    = is_posted_cmd(cmd) && in_win && room;
  assign mwi    = (cmd == CMD_MEMWRI);
endmodule

// File: rtl/pwt_stop_gen.sv
module pwt_stop_gen
  import pwt_pkg::*;
#(
  parameter int unsigned CL_DW = 8,
  parameter int unsigned FREE_W = 6
) (
  input  logic [31:0]       addr,
  input  logic              mwi,
  input  logic [FREE_W-1:0] remain,
  output logic              stop_bound,
  output logic              stop_full
);
  assign stop_bound = at_block_end(addr, mwi, CL_DW);
  assign stop_full  = (remain == FREE_W'(1));
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h1000_0000,
  parameter logic [31:0] WIN_LIMIT = 32'h1FFF_FFFF,
  parameter int unsigned CL_DW = 8,
  parameter int unsigned FREE_W = 6,
  parameter int unsigned MIN_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [31:0]       ad,
  input  logic [3:0]        cbe_n,
  input  logic [FREE_W-1:0] q_free,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              claim_ev,
  output logic              xfer_ev,
  output logic              last_ev
);
  localparam logic [FREE_W-1:0] ONE = FREE_W'(1);

  st_e               st;
  logic              frame_q;
  logic [31:0]       cur_addr;
  logic              cur_mwi;
  logic [FREE_W-1:0] remain;
  logic              devsel_q, trdy_q, stop_q;

  logic              hit, hit_mwi;
  logic              start;
  logic [31:0]       sg_addr;
  logic [FREE_W-1:0] sg_rem;
  logic              stop_bound, stop_full, stop_next;

  pwt_claim #(
    .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT),
    .FREE_W(FREE_W), .MIN_DATA(MIN_DATA)
  ) u_claim (
    .addr(ad), .cmd(cbe_n), .q_free(q_free), .hit(hit), .mwi(hit_mwi)
  );

  // Look ahead to the phase the registered outputs will be driving next.
  assign sg_addr = (st == ST_XFER) ? (cur_addr + 32'd4) : cur_addr;
  assign sg_rem  = (st == ST_XFER) ? (remain - ONE) : remain;

  pwt_stop_gen #(.CL_DW(CL_DW), .FREE_W(FREE_W)) u_stop (
    .addr(sg_addr), .mwi(cur_mwi), .remain(sg_rem),
    .stop_bound(stop_bound), .stop_full(stop_full)
  );

  assign stop_next = stop_bound || stop_full;
  assign start     = (st == ST_IDLE) && frame_q && !frame_n;
  assign claim_ev  = start && hit;
  assign xfer_ev   = (st == ST_XFER) && !irdy_n;
  assign last_ev   = xfer_ev && (frame_n || !stop_q);

  assign devsel_n = devsel_q;
  assign trdy_n   = trdy_q;
  assign stop_n   = stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      frame_q  <= 1'b1;
      cur_addr <= '0;
      cur_mwi  <= 1'b0;
      remain   <= '0;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      stop_q   <= 1'b1;
    end else begin
      frame_q <= frame_n;
      unique case (st)
        ST_IDLE: begin
          if (claim_ev) begin
            cur_addr <= {ad[31:2], 2'b00};
            cur_mwi  <= hit_mwi;
            remain   <= q_free - ONE;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          devsel_q <= 1'b0;
          st       <= ST_DSEL;
        end
        ST_DSEL: begin
          trdy_q <= 1'b0;
          stop_q <= !stop_next;
          st     <= ST_XFER;
        end
        ST_XFER: begin
          if (xfer_ev) begin
            if (frame_n) begin
              devsel_q <= 1'b1;
              trdy_q   <= 1'b1;
              stop_q   <= 1'b1;
              st       <= ST_IDLE;
            end else if (!stop_q) begin
              trdy_q <= 1'b1;
              st     <= ST_HOLD;
            end else begin
              cur_addr <= cur_addr + 32'd4;
              remain   <= remain - ONE;
              stop_q   <= !stop_next;
            end
          end
        end
        ST_HOLD: begin
          if (frame_n) begin
            devsel_q <= 1'b1;
            stop_q   <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: TRDY# first falls only after DEVSEL# was already low a clock earlier.
  p_trdy_after_devsel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_q) |-> $past(!devsel_q));

  // R9: STOP# is never driven without DEVSEL#.
  p_stop_with_devsel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |-> !devsel_q);

  // R10: a Dword taken with FRAME# high releases every drive on the next clock.
  p_release_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ev && frame_n) |=> (devsel_q && trdy_q && stop_q));

  // R8: while data flows, at least one queue slot remains reserved.
  p_budget_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER) |-> (remain != '0));

  // R4: once running, TRDY# holds low until the burst ends or disconnects.
  p_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == ST_XFER) && !$past(xfer_ev)) |-> !trdy_q);
endmodule

// File: rtl/pwt_qwrite.sv
module pwt_qwrite
  import pwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        claim_ev,
  input  logic        xfer_ev,
  input  logic        last_ev,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe_n,
  output logic        q_push,
  output logic [1:0]  q_tag,
  output logic [31:0] q_data,
  output logic [3:0]  q_be
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_push <= 1'b0;
      q_tag  <= TAG_NONE;
      q_data <= '0;
      q_be   <= '0;
    end else begin
      q_push <= claim_ev || xfer_ev;
      if (claim_ev) begin
        q_tag  <= TAG_ADDR;
        q_data <= ad;
        q_be   <= cbe_n;
      end else if (xfer_ev) begin
        q_tag  <= last_ev ? TAG_LAST : TAG_DATA;
        q_data <= ad;
        q_be   <= ~cbe_n;
      end else begin
        q_tag <= TAG_NONE;
      end
    end
  end

  // Tracks whether a transaction is open in the pushed stream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else if (q_push) open_q <= (q_tag == TAG_ADDR) || (q_tag == TAG_DATA);
  end

  // R5: an address entry never lands inside an unfinished transaction.
  p_addr_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && (q_tag == TAG_ADDR)) |-> !open_q);

  // R11: data entries only follow an address entry of the same transaction.
  p_data_inside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && (q_tag != TAG_ADDR)) |-> open_q);
endmodule

// File: rtl/pwt_acceptor.sv
module pwt_acceptor
  import pwt_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h1000_0000,
  parameter logic [31:0] WIN_LIMIT = 32'h1FFF_FFFF,
  parameter int unsigned CL_DW = 8,
  parameter int unsigned FREE_W = 6,
  parameter int unsigned MIN_DATA = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [31:0]       ad,
  input  logic [3:0]        cbe_n,
  input  logic [FREE_W-1:0] q_free,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              q_push,
  output logic [1:0]        q_tag,
  output logic [31:0]       q_data,
  output logic [3:0]        q_be
);
  logic claim_ev, xfer_ev, last_ev;

  pwt_ctrl #(
    .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT), .CL_DW(CL_DW),
    .FREE_W(FREE_W), .MIN_DATA(MIN_DATA)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .q_free(q_free),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .claim_ev(claim_ev), .xfer_ev(xfer_ev), .last_ev(last_ev)
  );

  pwt_qwrite u_qw (
    .clk(clk), .rst_n(rst_n), .claim_ev(claim_ev), .xfer_ev(xfer_ev),
    .last_ev(last_ev), .ad(ad), .cbe_n(cbe_n),
    .q_push(q_push), .q_tag(q_tag), .q_data(q_data), .q_be(q_be)
  );

  // R1: nothing is ever claimed while a non-posted command sits on the bus.
  p_claim_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    claim_ev |-> ((cbe_n == CMD_MEMWR) || (cbe_n == CMD_MEMWRI)));
endmodule

// File: tb/sim_pwt_acceptor.sv
`timescale 1ns/1ps
module sim_pwt_acceptor;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam logic [31:0] LIMIT = 32'h1FFF_FFFF;
  localparam int CL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0] cbe_n = 4'hF;
  logic [5:0] q_free = 6'd0;
  logic devsel_n, trdy_n, stop_n, q_push;
  logic [1:0] q_tag;
  logic [31:0] q_data;
  logic [3:0] q_be;

  int tests = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  pwt_acceptor u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .q_free(q_free), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .q_push(q_push), .q_tag(q_tag), .q_data(q_data), .q_be(q_be)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_claim(input logic [31:0] a, input logic [3:0] c, input int fr);
    return (c == 4'b0111 || c == 4'b1111) && a >= BASE && a <= LIMIT && fr >= 9;
  endfunction

  // Dwords from a up to and including the end of its block.
  function automatic int words_to_edge(input logic [31:0] a, input logic [3:0] c);
    int idx;
    idx = int'(a[11:2]);
    if (c == 4'b1111) return CL - (idx % CL);
    return 1024 - idx;
  endfunction

  function automatic int imin(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  task automatic run_burst(input logic [31:0] a, input logic [3:0] c, input int n,
                           input int fr, input int wp);
    logic [31:0] dw[64];
    logic [3:0]  bw[64];
    logic [1:0]  ptag[72];
    logic [31:0] pdat[72];
    logic [3:0]  pbe[72];
    bit claim, pend, pstop, pframe, done, lastdrv, devseen, tbad, dbad;
    int lim, xw, k, cyc, npush, edge_w;
    string sreq;

    for (int i = 0; i < 64; i++) begin
      dw[i] = $urandom;
      bw[i] = 4'($urandom);
    end
    claim  = exp_claim(a, c, fr);
    edge_w = words_to_edge(a, c);
    lim    = imin(edge_w, fr - 1);
    xw     = imin(n, lim);
    if (edge_w <= fr - 1) sreq = (c == 4'b1111) ? "R6" : "R7";
    else sreq = "R8";

    @(negedge clk);
    q_free = 6'(fr);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c;
    k = 0; cyc = 0; npush = 0; pend = 0; pstop = 0; pframe = 0;
    done = 0; lastdrv = 0; devseen = 0; tbad = 0;

    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (q_push && npush < 72) begin
        ptag[npush] = q_tag; pdat[npush] = q_data; pbe[npush] = q_be; npush++;
      end
      if (!devsel_n) devseen = 1;
      if (claim) begin
        if (cyc == 1) chk(devsel_n == 1'b1, "R3 devsel too early", devsel_n, 1);
        if (cyc == 2) chk(devsel_n == 1'b0 && trdy_n == 1'b1, "R3 medium devsel",
                          {devsel_n, trdy_n}, 2'b01);
        if (cyc == 3) chk(trdy_n == 1'b0, "R3 trdy one clock after devsel", trdy_n, 0);
      end
      if (pend) begin
        chk(pstop == (k == lim - 1), sreq, pstop, (k == lim - 1));
        k++;
        if (pframe) begin
          chk({devsel_n, trdy_n, stop_n} == 3'b111, "R10 release", {devsel_n, trdy_n, stop_n}, 3'b111);
          frame_n = 1'b1; irdy_n = 1'b1;
          done = 1;
        end else if (pstop) begin
          chk({devsel_n, trdy_n, stop_n} == 3'b010, "R9 hold after disconnect",
              {devsel_n, trdy_n, stop_n}, 3'b010);
          frame_n = 1'b1; irdy_n = 1'b0;
          done = 1;
        end
      end
      if (!done) begin
        if (!claim) begin
          frame_n = 1'b1;
          irdy_n = (cyc == 1) ? 1'b0 : 1'b1;
          if (cyc == 6) done = 1;
        end else begin
          if (cyc >= 3 && trdy_n) tbad = 1;
          ad = dw[k]; cbe_n = bw[k];
          if (lastdrv) begin
            frame_n = 1'b1; irdy_n = 1'b0;
          end else begin
            irdy_n = (($urandom % 100) < wp);
            frame_n = (k == n - 1) && !irdy_n;
            lastdrv = frame_n;
          end
          pend = !irdy_n && !trdy_n;
          pstop = !stop_n;
          pframe = frame_n;
        end
      end
    end

    for (int d = 0; d < 3; d++) begin
      @(negedge clk);
      if (q_push && npush < 72) begin
        ptag[npush] = q_tag; pdat[npush] = q_data; pbe[npush] = q_be; npush++;
      end
      frame_n = 1'b1; irdy_n = 1'b1;
    end
    chk({devsel_n, trdy_n, stop_n} == 3'b111, "R9/R10 idle after burst",
        {devsel_n, trdy_n, stop_n}, 3'b111);

    if (claim) begin
      chk(!tbad, "R4 no wait states", tbad, 0);
      chk(k == xw, "R4 Dwords taken", k, xw);
      chk(npush == xw + 1 && npush <= fr, "R8 entry count", npush, xw + 1);
      chk(npush > 0 && ptag[0] == 2'b01 && pdat[0] == a && pbe[0] == c,
          "R5 address entry", {ptag[0], pbe[0]}, {2'b01, c});
      dbad = 0;
      for (int j = 1; j < npush; j++) begin
        if (pdat[j] != dw[j-1] || pbe[j] != ~bw[j-1]) dbad = 1;
        if (ptag[j] != ((j == npush - 1) ? 2'b11 : 2'b10)) dbad = 1;
      end
      chk(!dbad, "R5/R11 data entries and last tag", dbad, 0);
    end else begin
      chk(!devseen && npush == 0, "R1/R2 not claimed", {devseen, 6'(npush)}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({devsel_n, trdy_n, stop_n, q_push} == 4'b1110, "R10 reset state",
        {devsel_n, trdy_n, stop_n, q_push}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_burst(32'h1000_0100, 4'b0111, 5, 40, 0);   // R4 R10 plain burst
    run_burst(32'h1000_000C, 4'b1111, 20, 40, 20); // R6 line end
    run_burst(32'h1000_0FF0, 4'b0111, 10, 40, 0);  // R7 page end
    run_burst(32'h1000_2000, 4'b0111, 20, 12, 10); // R8 queue full
    run_burst(32'h1000_3000, 4'b0111, 4, 8, 0);    // R2 too little room
    run_burst(32'h1000_3000, 4'b0110, 4, 40, 0);   // R1 wrong command
    run_burst(32'h2000_0000, 4'b0111, 4, 40, 0);   // R1 outside window
    run_burst(32'h1000_4000, 4'b0111, 1, 9, 0);    // single Dword, R11
    run_burst(32'h1000_5000, 4'b1111, 8, 40, 0);   // R6 with FRAME# ending too
    run_burst(32'h1000_6000, 4'b0111, 9, 9, 0);    // R8 exact budget

    for (int t = 0; t < 40; t++) begin
      logic [31:0] a;
      logic [3:0] c;
      int sel;
      sel = int'($urandom % 8);
      c = (sel < 4) ? 4'b0111 : (sel < 7) ? 4'b1111 : 4'b0110;
      a = (($urandom % 10) == 0) ? 32'h3000_0000 : (BASE | ({$urandom} & 32'h0000_FFFC));
      run_burst(a, c, 1 + int'($urandom % 40), 5 + int'($urandom % 59), 30);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule